// File: doc/BRIEF.md
# Cascaded Interrupt Status Encoder

This block gathers interrupt requests from three tiers and shows them as one encoded status word: a critical tier of four sources, a main tier of up to 17 sources and a peripheral tier of up to 32 sources. Each tier has a valid flag and the number of its lowest-numbered pending, unmasked source. Peripheral source 0 is not a pin. It is fed by a second-level DMA pending register, which has its own enable mask, write-one-to-clear pending bits, and lowest-set-bit selection.

Two source codes forward a request to the peripheral tier. Critical code 2 stands for a pending peripheral in a high-priority set, fixed by a parameter. Main code 4 stands for any other pending peripheral. Besides the status word, the block resolves one final winner across the tiers as a kind code and a source number, and it drives an interrupt line and a critical interrupt line.

Software sees the status word and the mask registers through a simple register port. Writes take effect at the next clock edge. Reads are combinational.

Top module: `irq_tier_encoder`

## Requirements
- R1: The status word (address 0) holds the critical valid flag in bit 10 and its number in bits 9:8, the main valid flag in bit 21 and its number in bits 20:16, and the peripheral valid flag in bit 29 and its number in bits 28:24. A field whose flag is 0 reads as zero, so the status word is 0 when nothing is pending.
- R2: The winner outputs follow the order critical, then main, then peripheral. The kind codes are 0 none, 1 critical, 2 main, 3 peripheral and 4 DMA.
- R3: Within each tier, the lowest-numbered pending unmasked source is reported.
- R4: The main mask register (address 1) disables main source n when bit 16-n is 1. Its reset value is 0x00010FFF.
- R5: The peripheral mask register (address 2) disables peripheral source n when bit 31-n is 1. Its reset value is 0x7FFFFC00.
- R6: Peripheral source 0 is pending when any DMA pending bit is set and not disabled by the DMA mask (address 3, where a 1 disables, reset 0xFFFFFFFF). When peripheral source 0 wins, the winner is kind 4 and its number is the lowest such DMA bit.
- R7: DMA events set bits in the DMA pending register (address 4, reset 0). Writing 1 to a pending bit clears it, writing all ones clears every bit, and the mask does not stop a bit from being recorded.
- R8: A DMA event that arrives in the same cycle as a clear of the same bit leaves that bit set.
- R9: Critical code 2 is raised when a pending unmasked peripheral lies in the high-priority set. The peripheral field then reports the lowest such source, and the winner resolves to that peripheral (or to DMA when it is source 0).
- R10: Main code 4 is raised when a pending unmasked peripheral lies outside the high-priority set. When it wins, the winner resolves through the peripheral field.
- R11: The external critical request bit 2, the main request bit 4 and the peripheral request bit 0 have no effect.
- R12: irq_o is 1 exactly when some tier flag in the status word is 1, and crit_irq_o is 1 exactly when the critical flag is 1.
- R13: Writes to the status address are ignored. Addresses 5 to 7 read as 0. The status and winner outputs are registered one clock after the requests they reflect.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Active-low synchronous reset |
| crit_req_i | input | 4 | Critical tier requests (bit 2 unused) |
| main_req_i | input | 17 | Main tier requests (bit 4 unused) |
| peri_req_i | input | 32 | Peripheral tier requests (bit 0 unused) |
| dma_evt_i | input | 32 | DMA events that set pending bits |
| reg_we_i | input | 1 | Register write strobe |
| reg_addr_i | input | 3 | Register address |
| reg_wdata_i | input | 32 | Register write data |
| reg_rdata_o | output | 32 | Register read data |
| irq_o | output | 1 | Any tier valid |
| crit_irq_o | output | 1 | Critical tier valid |
| win_kind_o | output | 3 | Resolved winner kind |
| win_id_o | output | 5 | Resolved winner source number |

## Verification
The assertions assume that reset is held for at least one clock edge and that DMA events and register writes are seen only at clock edges. They also assume that the status and winner outputs are judged in the cycle after their inputs, never in the same cycle. The bench drives every input half a period away from the sampling edge, holds each request pattern for several cycles, and compares outputs only after the one-cycle register stage and the mask write stage have settled. The collision check is the exception: it deliberately places an event and a clear in the same cycle.

// File: rtl/irq_tier_pkg.sv
package irq_tier_pkg;

    localparam int unsigned STAT_W       = 32;
    localparam int unsigned SRC_W        = 5;
    localparam int unsigned ADDR_W       = 3;

    // status word layout, decoded by software
    localparam int unsigned CRIT_VLD_BIT = 10;
    localparam int unsigned CRIT_NUM_LSB = 8;
    localparam int unsigned CRIT_NUM_W   = 2;
    localparam int unsigned MAIN_VLD_BIT = 21;
    localparam int unsigned MAIN_NUM_LSB = 16;
    localparam int unsigned MAIN_NUM_W   = 5;
    localparam int unsigned PERI_VLD_BIT = 29;
    localparam int unsigned PERI_NUM_LSB = 24;
    localparam int unsigned PERI_NUM_W   = 5;

    // forwarding codes into the peripheral tier
    localparam int unsigned CRIT_FWD_SRC = 2;
    localparam int unsigned MAIN_FWD_SRC = 4;
    localparam int unsigned PERI_DMA_SRC = 0;

    typedef enum logic [2:0] {
        WIN_NONE = 3'd0,
        WIN_CRIT = 3'd1,
        WIN_MAIN = 3'd2,
        WIN_PERI = 3'd3,
        WIN_DMA  = 3'd4
    } win_kind_e;

    typedef enum logic [ADDR_W-1:0] {
        RA_STATUS    = 3'd0,
        RA_MAIN_MASK = 3'd1,
        RA_PERI_MASK = 3'd2,
        RA_DMA_MASK  = 3'd3,
        RA_DMA_PEND  = 3'd4
    } reg_addr_e;

endpackage

// File: rtl/irq_lowest_pick.sv
module irq_lowest_pick #(
    parameter int unsigned W   = 32,
    localparam int unsigned IDW = (W > 1) ? $clog2(W) : 1
) (
    input  logic [W-1:0]   req_i,
    output logic           vld_o,
    output logic [IDW-1:0] idx_o
);

    always_comb begin
        idx_o = '0;
        for (int i = W - 1; i >= 0; i--) begin
            if (req_i[i]) begin
                idx_o = IDW'(i);
            end
        end
    end

    assign vld_o = |req_i;

endmodule

// File: rtl/irq_dma_cascade.sv
module irq_dma_cascade #(
    parameter int unsigned     N_DMA    = 32,
    parameter logic [N_DMA-1:0] MASK_RST = '1,
    localparam int unsigned    IDW      = (N_DMA > 1) ? $clog2(N_DMA) : 1
) (
    input  logic             clk_i,
    input  logic             rst_ni,
    input  logic [N_DMA-1:0] evt_i,
    input  logic             mask_we_i,
    input  logic             pend_we_i,
    input  logic [N_DMA-1:0] wdata_i,
    output logic [N_DMA-1:0] pend_o,
    output logic [N_DMA-1:0] mask_o,
    output logic             any_o,
    output logic [IDW-1:0]   id_o
);

    typedef struct packed {
        logic [N_DMA-1:0] pend;
        logic [N_DMA-1:0] mask;
    } dma_st_t;

    dma_st_t          st_d, st_q;
    logic [N_DMA-1:0] live;

    always_comb begin
        st_d = st_q;
        if (mask_we_i) begin
            st_d.mask = wdata_i;
        end
        // clear first, then new events, so an event survives a clear
        if (pend_we_i) begin
            st_d.pend = st_q.pend & ~wdata_i;
        end
        st_d.pend = st_d.pend | evt_i;
    end

    always_ff @(posedge clk_i) begin
        if (!rst_ni) begin
            st_q <= '{pend: '0, mask: MASK_RST};
        end else begin
            st_q <= st_d;
        end
    end

    assign live   = st_q.pend & ~st_q.mask;
    assign pend_o = st_q.pend;
    assign mask_o = st_q.mask;

    irq_lowest_pick #(.W(N_DMA)) u_pick (
        .req_i (live),
        .vld_o (any_o),
        .idx_o (id_o)
    );

endmodule

// File: rtl/irq_tier_encoder.sv
module irq_tier_encoder
    import irq_tier_pkg::*;
#(
    parameter int unsigned       N_CRIT        = 4,
    parameter int unsigned       N_MAIN        = 17,
    parameter int unsigned       N_PERI        = 32,
    parameter int unsigned       N_DMA         = 32,
    parameter logic [N_PERI-1:0] HI_PERI_SET   = '0,
    parameter logic [N_MAIN-1:0] MAIN_MASK_RST = 17'h10FFF,
    parameter logic [N_PERI-1:0] PERI_MASK_RST = 32'h7FFFFC00,
    parameter logic [N_DMA-1:0]  DMA_MASK_RST  = '1
) (
    input  logic              clk_i,
    input  logic              rst_ni,
    input  logic [N_CRIT-1:0] crit_req_i,
    input  logic [N_MAIN-1:0] main_req_i,
    input  logic [N_PERI-1:0] peri_req_i,
    input  logic [N_DMA-1:0]  dma_evt_i,
    input  logic              reg_we_i,
    input  logic [ADDR_W-1:0] reg_addr_i,
    input  logic [31:0]       reg_wdata_i,
    output logic [31:0]       reg_rdata_o,
    output logic              irq_o,
    output logic              crit_irq_o,
    output logic [2:0]        win_kind_o,
    output logic [SRC_W-1:0]  win_id_o
);

    localparam int unsigned CIDW = (N_CRIT > 1) ? $clog2(N_CRIT) : 1;
    localparam int unsigned MIDW = (N_MAIN > 1) ? $clog2(N_MAIN) : 1;
    localparam int unsigned PIDW = (N_PERI > 1) ? $clog2(N_PERI) : 1;
    localparam int unsigned DIDW = (N_DMA  > 1) ? $clog2(N_DMA)  : 1;

    typedef struct packed {
        logic [N_MAIN-1:0] main_mask;
        logic [N_PERI-1:0] peri_mask;
        logic [STAT_W-1:0] status;
        win_kind_e         kind;
        logic [SRC_W-1:0]  id;
    } enc_st_t;

    enc_st_t st_d, st_q;

    reg_addr_e addr;
    assign addr = reg_addr_e'(reg_addr_i);

    // ---------------- DMA cascade ----------------
    logic [N_DMA-1:0] dma_pend, dma_mask;
    logic             dma_any;
    logic [DIDW-1:0]  dma_id;

    irq_dma_cascade #(
        .N_DMA    (N_DMA),
        .MASK_RST (DMA_MASK_RST)
    ) u_dma (
        .clk_i     (clk_i),
        .rst_ni    (rst_ni),
        .evt_i     (dma_evt_i),
        .mask_we_i (reg_we_i && (addr == RA_DMA_MASK)),
        .pend_we_i (reg_we_i && (addr == RA_DMA_PEND)),
        .wdata_i   (reg_wdata_i[N_DMA-1:0]),
        .pend_o    (dma_pend),
        .mask_o    (dma_mask),
        .any_o     (dma_any),
        .id_o      (dma_id)
    );

    // ---------------- request vectors ----------------
    logic [N_PERI-1:0] peri_raw, peri_eff, peri_hi, peri_lo;
    logic [N_CRIT-1:0] crit_vec;
    logic [N_MAIN-1:0] main_raw, main_eff;
    logic              hi_any, lo_any;

    always_comb begin
        peri_raw               = peri_req_i;
        peri_raw[PERI_DMA_SRC] = dma_any;
        for (int n = 0; n < N_PERI; n++) begin
            peri_eff[n] = peri_raw[n] & ~st_q.peri_mask[N_PERI-1-n];
        end
        peri_hi = peri_eff & HI_PERI_SET;
        peri_lo = peri_eff & ~HI_PERI_SET;
    end

    assign hi_any = |peri_hi;
    assign lo_any = |peri_lo;

    always_comb begin
        crit_vec               = crit_req_i;
        crit_vec[CRIT_FWD_SRC] = hi_any;
        main_raw               = main_req_i;
        main_raw[MAIN_FWD_SRC] = lo_any;
        for (int n = 0; n < N_MAIN; n++) begin
            main_eff[n] = main_raw[n] & ~st_q.main_mask[N_MAIN-1-n];
        end
    end

    // ---------------- per-tier selection ----------------
    logic            crit_vld, main_vld, peri_vld, phi_vld;
    logic [CIDW-1:0] crit_idx;
    logic [MIDW-1:0] main_idx;
    logic [PIDW-1:0] peri_idx, phi_idx;

    irq_lowest_pick #(.W(N_CRIT)) u_pick_crit (
        .req_i (crit_vec), .vld_o (crit_vld), .idx_o (crit_idx)
    );
    irq_lowest_pick #(.W(N_MAIN)) u_pick_main (
        .req_i (main_eff), .vld_o (main_vld), .idx_o (main_idx)
    );
    irq_lowest_pick #(.W(N_PERI)) u_pick_peri (
        .req_i (peri_eff), .vld_o (peri_vld), .idx_o (peri_idx)
    );
    irq_lowest_pick #(.W(N_PERI)) u_pick_phi (
        .req_i (peri_hi), .vld_o (phi_vld), .idx_o (phi_idx)
    );

    // ---------------- next state ----------------
    logic [SRC_W-1:0] crit_num, main_num, peri_num;
    win_kind_e        peri_kind;
    logic [SRC_W-1:0] peri_wid;

    always_comb begin
        crit_num = crit_vld ? SRC_W'(crit_idx) : '0;
        main_num = main_vld ? SRC_W'(main_idx) : '0;
        peri_num = '0;
        if (phi_vld) begin
            peri_num = SRC_W'(phi_idx);
        end else if (peri_vld) begin
            peri_num = SRC_W'(peri_idx);
        end

        if (peri_num == SRC_W'(PERI_DMA_SRC)) begin
            peri_kind = WIN_DMA;
            peri_wid  = SRC_W'(dma_id);
        end else begin
            peri_kind = WIN_PERI;
            peri_wid  = peri_num;
        end
    end

    always_comb begin
        st_d = st_q;

        if (reg_we_i) begin
            case (addr)
                RA_MAIN_MASK: st_d.main_mask = reg_wdata_i[N_MAIN-1:0];
                RA_PERI_MASK: st_d.peri_mask = reg_wdata_i[N_PERI-1:0];
                default: ;
            endcase
        end

        st_d.status = '0;
        st_d.status[CRIT_VLD_BIT] = crit_vld;
        st_d.status[CRIT_NUM_LSB +: CRIT_NUM_W] = CRIT_NUM_W'(crit_num);
        st_d.status[MAIN_VLD_BIT] = main_vld;
        st_d.status[MAIN_NUM_LSB +: MAIN_NUM_W] = MAIN_NUM_W'(main_num);
        st_d.status[PERI_VLD_BIT] = peri_vld;
        st_d.status[PERI_NUM_LSB +: PERI_NUM_W] = PERI_NUM_W'(peri_num);

        st_d.kind = WIN_NONE;
        st_d.id   = '0;
        if (crit_vld) begin
            if (crit_num == SRC_W'(CRIT_FWD_SRC)) begin
                st_d.kind = peri_kind;
                st_d.id   = peri_wid;
            end else begin
                st_d.kind = WIN_CRIT;
                st_d.id   = crit_num;
            end
        end else if (main_vld) begin
            if (main_num == SRC_W'(MAIN_FWD_SRC)) begin
                st_d.kind = peri_kind;
                st_d.id   = peri_wid;
            end else begin
                st_d.kind = WIN_MAIN;
                st_d.id   = main_num;
            end
        end else if (peri_vld) begin
            st_d.kind = peri_kind;
            st_d.id   = peri_wid;
        end
    end

    always_ff @(posedge clk_i) begin
        if (!rst_ni) begin
            st_q <= '{main_mask: MAIN_MASK_RST,
                      peri_mask: PERI_MASK_RST,
                      status:    '0,
                      kind:      WIN_NONE,
                      id:        '0};
        end else begin
            st_q <= st_d;
        end
    end

    // ---------------- outputs ----------------
    logic [STAT_W-1:0] status_q;
    assign status_q = st_q.status;

    always_comb begin
        case (addr)
            RA_STATUS:    reg_rdata_o = status_q;
            RA_MAIN_MASK: reg_rdata_o = 32'(st_q.main_mask);
            RA_PERI_MASK: reg_rdata_o = 32'(st_q.peri_mask);
            RA_DMA_MASK:  reg_rdata_o = 32'(dma_mask);
            RA_DMA_PEND:  reg_rdata_o = 32'(dma_pend);
            default:      reg_rdata_o = '0;
        endcase
    end

    assign irq_o      = status_q[CRIT_VLD_BIT] | status_q[MAIN_VLD_BIT] | status_q[PERI_VLD_BIT];
    assign crit_irq_o = status_q[CRIT_VLD_BIT];
    assign win_kind_o = st_q.kind;
    assign win_id_o   = st_q.id;

endmodule

// File: rtl/irq_tier_encoder_chk.sv
module irq_tier_encoder_chk
    import irq_tier_pkg::*;
#(
    parameter int unsigned N_DMA = 32
) (
    input logic              clk_i,
    input logic              rst_ni,
    input logic              reg_we_i,
    input logic [ADDR_W-1:0] reg_addr_i,
    input logic [31:0]       reg_wdata_i,
    input logic [N_DMA-1:0]  dma_evt_i,
    input logic [N_DMA-1:0]  dma_pend_i,
    input logic [31:0]       status_i,
    input logic              irq_i,
    input logic              crit_irq_i,
    input logic [2:0]        win_kind_i,
    input logic [SRC_W-1:0]  win_id_i
);

    // R1: quiet line means an all-zero status word
    p_idle_zero_r1: assert property (@(posedge clk_i) disable iff (!rst_ni)
        !irq_i |-> (status_i == '0));

    // R1: a field without its flag reads as zero
    p_field_clean_r1: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (!status_i[MAIN_VLD_BIT] |-> (status_i[MAIN_NUM_LSB +: MAIN_NUM_W] == '0)) and
        (!status_i[PERI_VLD_BIT] |-> (status_i[PERI_NUM_LSB +: PERI_NUM_W] == '0)));

    // R2: a non-forwarding critical source owns the winner
    p_crit_wins_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (status_i[CRIT_VLD_BIT] && (status_i[CRIT_NUM_LSB +: CRIT_NUM_W] != 2'(CRIT_FWD_SRC)))
        |-> (win_kind_i == WIN_CRIT));

    // R6: a DMA winner only appears through peripheral source 0
    p_dma_via_slot0_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (win_kind_i == WIN_DMA) |->
        (status_i[PERI_VLD_BIT] && (status_i[PERI_NUM_LSB +: PERI_NUM_W] == '0)));

    // R7: an all-ones clear with no events empties the pending register
    p_clear_all_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (reg_we_i && (reg_addr_i == RA_DMA_PEND) && (&reg_wdata_i[N_DMA-1:0]) &&
         (dma_evt_i == '0)) |=> (dma_pend_i == '0));

    // R8: every event is recorded even under a same-cycle clear
    p_event_kept_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (dma_evt_i != '0) |=> ((dma_pend_i & $past(dma_evt_i)) == $past(dma_evt_i)));

    // R12: the critical line follows the critical flag
    p_crit_line_r12: assert property (@(posedge clk_i) disable iff (!rst_ni)
        crit_irq_i == status_i[CRIT_VLD_BIT]);

    // R2: no winner without an interrupt
    p_none_quiet_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (win_kind_i == WIN_NONE) |-> !irq_i);

endmodule

bind irq_tier_encoder irq_tier_encoder_chk #(.N_DMA(N_DMA)) u_chk (
    .clk_i       (clk_i),
    .rst_ni      (rst_ni),
    .reg_we_i    (reg_we_i),
    .reg_addr_i  (reg_addr_i),
    .reg_wdata_i (reg_wdata_i),
    .dma_evt_i   (dma_evt_i),
    .dma_pend_i  (dma_pend),
    .status_i    (status_q),
    .irq_i       (irq_o),
    .crit_irq_i  (crit_irq_o),
    .win_kind_i  (win_kind_o),
    .win_id_i    (win_id_o)
);

// File: tb/irq_tier_encoder_tb.sv
module irq_tier_encoder_tb;

    localparam int CLK_PERIOD = 10;
    localparam logic [31:0] HI = 32'h0000_00C0;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [3:0]  crit_req = '0;
    logic [16:0] main_req = '0;
    logic [31:0] peri_req = '0;
    logic [31:0] dma_evt = '0;
    logic        we = 1'b0;
    logic [2:0]  addr = '0;
    logic [31:0] wdata = '0;
    logic [31:0] rdata;
    logic        irq, crit_irq;
    logic [2:0]  kind;
    logic [4:0]  wid;

    int checks = 0;
    int errors = 0;

    // bench-held picture of the programmable state
    logic [16:0] m_main = 17'h10FFF;
    logic [31:0] m_peri = 32'h7FFFFC00;
    logic [31:0] m_dmam = 32'hFFFFFFFF;
    logic [31:0] m_pend = 32'h0;

    always #(CLK_PERIOD/2) clk = ~clk;

    irq_tier_encoder #(.HI_PERI_SET(HI)) u_dut (
        .clk_i(clk), .rst_ni(rst_n),
        .crit_req_i(crit_req), .main_req_i(main_req), .peri_req_i(peri_req),
        .dma_evt_i(dma_evt),
        .reg_we_i(we), .reg_addr_i(addr), .reg_wdata_i(wdata), .reg_rdata_o(rdata),
        .irq_o(irq), .crit_irq_o(crit_irq), .win_kind_o(kind), .win_id_o(wid)
    );

    initial begin
        repeat (150000) @(posedge clk);
        errors++;
        $display("FAIL watchdog expired");
        $display("  CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s actual %h expected %h", tag, act, exp);
        end
    endtask

    function automatic int low(input logic [31:0] v);
        for (int i = 0; i < 32; i++) if (v[i]) return i;
        return -1;
    endfunction

    // expected status/kind/id from the requirement text
    task automatic model(output logic [31:0] st, output logic [2:0] k, output logic [4:0] id);
        logic [31:0] pe, praw, hiv;
        logic [3:0]  cv;
        logic [16:0] me, mraw;
        int c, m, p, ph, pn, dl;
        logic [2:0] pk; logic [4:0] pid;
        dl = low(m_pend & ~m_dmam);
        praw = peri_req; praw[0] = (dl >= 0);
        for (int n = 0; n < 32; n++) pe[n] = praw[n] & ~m_peri[31-n];
        hiv = pe & HI;
        cv = crit_req; cv[2] = |hiv;
        mraw = main_req; mraw[4] = |(pe & ~HI);
        for (int n = 0; n < 17; n++) me[n] = mraw[n] & ~m_main[16-n];
        c = low({28'd0, cv}); m = low({15'd0, me}); p = low(pe); ph = low(hiv);
        pn = (ph >= 0) ? ph : p;
        st = 32'h0;
        if (c >= 0) st = st | 32'h400 | (32'(c) << 8);
        if (m >= 0) st = st | 32'h200000 | (32'(m) << 16);
        if (pn >= 0) st = st | 32'h20000000 | (32'(pn) << 24);
        if (pn == 0) begin pk = 3'd4; pid = 5'(dl); end
        else begin pk = 3'd3; pid = 5'(pn); end
        if (c >= 0) begin
            if (c == 2) begin k = pk; id = pid; end else begin k = 3'd1; id = 5'(c); end
        end else if (m >= 0) begin
            if (m == 4) begin k = pk; id = pid; end else begin k = 3'd2; id = 5'(m); end
        end else if (pn >= 0) begin k = pk; id = pid; end
        else begin k = 3'd0; id = 5'd0; end
    endtask

    task automatic settle();
        repeat (3) @(negedge clk);
    endtask

    task automatic wr(input logic [2:0] a, input logic [31:0] d);
        @(negedge clk);
        we = 1'b1; addr = a; wdata = d;
        @(negedge clk);
        we = 1'b0; addr = 3'd0;
        case (a)
            3'd1: m_main = d[16:0];
            3'd2: m_peri = d;
            3'd3: m_dmam = d;
            3'd4: m_pend = m_pend & ~d;
            default: ;
        endcase
    endtask

    task automatic pulse(input logic [31:0] e);
        @(negedge clk);
        dma_evt = e;
        @(negedge clk);
        dma_evt = '0;
        m_pend = m_pend | e;
    endtask

    task automatic rd(input logic [2:0] a, output logic [31:0] d);
        addr = a; #1; d = rdata; addr = 3'd0; #1;
    endtask

    task automatic check_model(input string tag);
        logic [31:0] st, r; logic [2:0] k; logic [4:0] id;
        model(st, k, id);
        rd(3'd0, r);
        chk({tag, " status"}, r, st);
        chk({tag, " kind"}, 32'(kind), 32'(k));
        chk({tag, " id"}, 32'(wid), 32'(id));
        chk({tag, " R12 irq"}, 32'(irq), 32'(st != 0));
        chk({tag, " R12 crit"}, 32'(crit_irq), 32'(st[10]));
        rd(3'd4, r);
        chk({tag, " R7 pend"}, r, m_pend);
    endtask

    initial begin
        logic [31:0] r;
        int seed;
        seed = $urandom(32'd2718);
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);

        // reset state
        rd(3'd0, r); chk("R1 reset status", r, 32'h0);
        rd(3'd1, r); chk("R4 reset main mask", r, 32'h00010FFF);
        rd(3'd2, r); chk("R5 reset peri mask", r, 32'h7FFFFC00);
        rd(3'd3, r); chk("R6 reset dma mask", r, 32'hFFFFFFFF);
        rd(3'd4, r); chk("R7 reset pend", r, 32'h0);
        rd(3'd6, r); chk("R13 unmapped read", r, 32'h0);
        chk("R12 reset irq", 32'(irq), 0);
        chk("R2 reset kind", 32'(kind), 0);

        // R3 lowest critical, R2 critical over main
        crit_req = 4'b1010; main_req = 17'h4;
        settle();
        rd(3'd0, r); chk("R3 crit lowest status", r, 32'h00220500);
        chk("R2 crit kind", 32'(kind), 1); chk("R3 crit id", 32'(wid), 1);

        // R2 main over peripheral, R3 lowest main
        crit_req = 0; main_req = 17'hC; peri_req = 32'h0200_0000;
        settle();
        rd(3'd0, r); chk("R2 main status", r, 32'h39220000);
        chk("R2 main kind", 32'(kind), 2); chk("R2 main id", 32'(wid), 2);

        // R10 main code 4 forwards to peripheral 25
        main_req = 0;
        settle();
        rd(3'd0, r); chk("R10 fwd status", r, 32'h39240000);
        chk("R10 fwd kind", 32'(kind), 3); chk("R10 fwd id", 32'(wid), 25);

        // R4 main mask position 16-n
        peri_req = 0; main_req = 17'h400;
        settle();
        rd(3'd0, r); chk("R4 masked main", r, 32'h0);
        wr(3'd1, 32'h00010FBF);
        settle();
        rd(3'd0, r); chk("R4 unmasked main", r, 32'h002A0000);
        chk("R4 main kind", 32'(kind), 2); chk("R4 main id", 32'(wid), 10);

        // R5 peripheral mask, R9 high-priority forwarding
        main_req = 0; peri_req = 32'h0200_0040;
        settle();
        rd(3'd0, r); chk("R5 masked peri 6", r, 32'h39240000);
        wr(3'd2, 32'h7DFFFC00);
        settle();
        rd(3'd0, r); chk("R9 hi status", r, 32'h26240600);
        chk("R9 hi kind", 32'(kind), 3); chk("R9 hi id", 32'(wid), 6);
        chk("R12 crit line", 32'(crit_irq), 1);

        // R11 ignored input bits
        peri_req = 32'h1; crit_req = 4'b0100; main_req = 17'h10;
        settle();
        rd(3'd0, r); chk("R11 ignored status", r, 32'h0);
        chk("R11 ignored irq", 32'(irq), 0);
        peri_req = 0; crit_req = 0; main_req = 0;

        // R6 DMA cascade with mask
        wr(3'd3, 32'hFFFFFDF7);
        pulse(32'h0010_0208);
        settle();
        rd(3'd4, r); chk("R7 pend set", r, 32'h00100208);
        rd(3'd0, r); chk("R6 dma status", r, 32'h20240000);
        chk("R6 dma kind", 32'(kind), 4); chk("R6 dma id", 32'(wid), 3);
        wr(3'd4, 32'h8);
        settle();
        chk("R7 w1c next id", 32'(wid), 9);
        rd(3'd4, r); chk("R7 w1c pend", r, 32'h00100200);
        wr(3'd4, 32'hFFFFFFFF);
        settle();
        rd(3'd4, r); chk("R7 clear all", r, 32'h0);
        rd(3'd0, r); chk("R7 cleared status", r, 32'h0);

        // R8 event and clear in one cycle
        pulse(32'h1);
        @(negedge clk);
        we = 1'b1; addr = 3'd4; wdata = 32'h21; dma_evt = 32'h20;
        @(negedge clk);
        we = 1'b0; addr = 3'd0; dma_evt = 0;
        m_pend = 32'h20;
        rd(3'd4, r); chk("R8 collision keeps bit", r, 32'h20);
        wr(3'd4, 32'hFFFFFFFF);

        // R13 status is read-only
        wr(3'd0, 32'hFFFFFFFF);
        settle();
        rd(3'd0, r); chk("R13 status write ignored", r, 32'h0);

        // random mix, R2 R3 R6 R9 R10 against the model
        for (int it = 0; it < 250; it++) begin
            crit_req = ($urandom % 4 == 0) ? 4'($urandom) : 4'd0;
            main_req = ($urandom % 2 == 0) ? 17'($urandom) : 17'd0;
            peri_req = ($urandom % 2 == 0) ? $urandom : 32'd0;
            if ($urandom % 5 == 0) wr(3'd1, $urandom);
            if ($urandom % 5 == 0) wr(3'd2, $urandom);
            if ($urandom % 5 == 0) wr(3'd3, $urandom);
            if ($urandom % 3 == 0) pulse($urandom & $urandom);
            if ($urandom % 4 == 0) wr(3'd4, $urandom);
            settle();
            check_model("R2 R3 random");
        end

        $display("  CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

endmodule